// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

This block moves data between two descriptor rings that live in a word-addressed local memory inside the block. A host programs each ring's base and entry count and sets a maximum transfer length. It then fills source descriptors and empty destination descriptors through a memory port. Writing a ring's write index hands the new entries to the engine.

The engine takes source descriptors in ring order and copies each referenced buffer into the buffer named by the oldest posted destination descriptor. Source descriptors flagged as gather are packed one after another into the same destination buffer. When the run ends, the engine writes the total byte count and flags into the destination descriptor, advances its destination read index and pulses `copy_done`. A non-zero count in a destination descriptor therefore means it is finished.

Top module: `desc_copy_engine`

## Requirements
- R1: After reset both read indices read 0, the error flag reads 0 and `copy_done` is low.
- R2: The register map is as follows. Address 0 holds the source ring base as a word address. Address 1 takes the source entry count, a power of two. Addresses 2 and 3 do the same for the destination ring. A write to address 4 sets the source write index and a read returns the source read index. Address 5 does the same for the destination ring. Address 6 holds the maximum transfer length in bits [15:0] and the ring swap enable in bit 16. Reading address 7 returns the error flag in bit 0, and writing address 7 clears it.
- R3: A descriptor is two words at ring base + 2*index. Word 0 is a word-aligned byte address. In word 1, bits [15:0] are the byte count and bits [31:16] are the flags: bit 16 is gather, bit 17 is swap and bits [31:20] are metadata. The engine copies ceil(count/4) words in order from the source buffer into the destination buffer and leaves the words after them untouched.
- R4: After the last data word of a run is written, the engine writes destination word 1. Its bits [15:0] hold the run's total byte count. Its bits [31:16] hold the flags of the run's last source descriptor, with bit 16 cleared and bit 17 set if a swap was applied. The destination read index then advances by one and `copy_done` is high for exactly one cycle.
- R5: Each read index advances by exactly one and wraps modulo the ring's entry count.
- R6: A new run starts only when the source write index differs from the source read index and the destination write index differs from the destination read index. Otherwise no index moves.
- R7: Descriptors carrying the gather flag are appended at word granularity into one destination buffer. A single completion is raised at the first descriptor without the flag. Partway through a run, the engine waits for further source descriptors without completing.
- R8: When the descriptor's swap flag or the ring swap enable is set, each copied word has its byte order reversed.
- R9: A descriptor whose count exceeds the maximum, or that would take the run total over the maximum, sets the error flag and is skipped. It is consumed without copying, and its gather flag still decides whether the run continues. A run whose total is zero completes nothing.
- R10: A ring with N entries accepts up to N-1 pending descriptors. These may be handed over with write-index updates on consecutive cycles, and all are processed in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_we | input | 1 | Host memory write strobe |
| mem_addr | input | AW | Host memory word address |
| mem_wdata | input | 32 | Host memory write data |
| mem_rdata | output | 32 | Host memory read data, combinational |
| copy_done | output | 1 | One-cycle copy-complete pulse |

## Verification
Two functions can land in the same cycle: the host posting new write indices, and the engine advancing its read index on the same ring. The bench provokes this by handing three prepared descriptors to the engine with write-index updates on back-to-back cycles while the engine is already consuming the first. The outcome is judged from the three destination descriptors, their data and the final read indices. The checks are made against values computed from the descriptor format. The sweep over byte counts 1 to 24 and the gather, overflow and ring-wrap cases complete the picture.

// File: rtl/desc_copy_engine.sv
`timescale 1ns/1ps
module desc_copy_engine #(
  parameter int MEM_WORDS = 256,
  parameter int IDXW = 4,
  localparam int AW = $clog2(MEM_WORDS)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_wdata,
  output logic [31:0]   mem_rdata,
  output logic          copy_done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_DOPEN, ST_SADDR, ST_SLEN, ST_RD, ST_WR, ST_SNEXT, ST_CLOSE
  } st_t;

  logic [31:0] mem [MEM_WORDS];

  st_t            state;
  logic [AW-1:0]  src_base, dst_base, sptr, dptr, eaddr;
  logic [IDXW-1:0] smask, dmask, src_wr, src_rd, dst_wr, dst_rd;
  logic [15:0]    max_len, total, cur_flags;
  logic           swap_en, err, in_run;
  logic [14:0]    wleft;
  logic [31:0]    hold, erd, ewd;
  logic           ewe;
  logic [AW-1:0]  sdesc, ddesc;
  logic [16:0]    sum;
  logic           too_big, go;
  logic [14:0]    nwords;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  assign sdesc   = src_base + AW'({src_rd, 1'b0});
  assign ddesc   = dst_base + AW'({dst_rd, 1'b0});
  assign go      = (src_wr != src_rd) && (in_run || (dst_wr != dst_rd));
  assign erd     = mem[eaddr];
  assign sum     = {1'b0, total} + {1'b0, erd[15:0]};
  assign too_big = (erd[15:0] > max_len) || (sum > {1'b0, max_len});
  assign nwords  = 15'(({1'b0, erd[15:0]} + 17'd3) >> 2);
  assign ewe     = (state == ST_WR) || (state == ST_CLOSE);
  assign ewd     = (state == ST_CLOSE) ?
                   {cur_flags[15:2], cur_flags[1] | swap_en, 1'b0, total} : hold;
  assign mem_rdata = mem[mem_addr];

  always_comb begin
    case (state)
      ST_DOPEN: eaddr = ddesc;
      ST_SLEN:  eaddr = sdesc + 1'b1;
      ST_RD:    eaddr = sptr;
      ST_WR:    eaddr = dptr;
      ST_CLOSE: eaddr = ddesc + 1'b1;
      default:  eaddr = sdesc;
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd4:    reg_rdata = 32'(src_rd);
      3'd5:    reg_rdata = 32'(dst_rd);
      3'd7:    reg_rdata = {31'd0, err};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (ewe)    mem[eaddr]    <= ewd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      src_base <= '0; dst_base <= '0; sptr <= '0; dptr <= '0;
      smask <= '0; dmask <= '0;
      src_wr <= '0; src_rd <= '0; dst_wr <= '0; dst_rd <= '0;
      max_len <= '1; swap_en <= 1'b0; err <= 1'b0; in_run <= 1'b0;
      total <= '0; cur_flags <= '0; wleft <= '0; hold <= '0;
      copy_done <= 1'b0;
    end else begin
      copy_done <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          3'd0: src_base <= reg_wdata[AW-1:0];
          3'd1: smask    <= IDXW'(reg_wdata - 32'd1);
          3'd2: dst_base <= reg_wdata[AW-1:0];
          3'd3: dmask    <= IDXW'(reg_wdata - 32'd1);
          3'd4: src_wr   <= reg_wdata[IDXW-1:0] & smask;
          3'd5: dst_wr   <= reg_wdata[IDXW-1:0] & dmask;
          3'd6: begin max_len <= reg_wdata[15:0]; swap_en <= reg_wdata[16]; end
          default: err <= 1'b0;
        endcase
      end
      case (state)
        ST_IDLE: if (go) state <= in_run ? ST_SADDR : ST_DOPEN;
        ST_DOPEN: begin
          dptr   <= erd[AW+1:2];
          total  <= '0;
          in_run <= 1'b1;
          state  <= ST_SADDR;
        end
        ST_SADDR: begin
          sptr  <= erd[AW+1:2];
          state <= ST_SLEN;
        end
        ST_SLEN: begin
          cur_flags <= erd[31:16];
          if (too_big) begin
            err   <= 1'b1;
            state <= ST_SNEXT;
          end else begin
            total <= sum[15:0];
            wleft <= nwords;
            state <= (nwords == '0) ? ST_SNEXT : ST_RD;
          end
        end
        ST_RD: begin
          hold  <= (cur_flags[1] | swap_en) ? bswap(erd) : erd;
          sptr  <= sptr + 1'b1;
          state <= ST_WR;
        end
        ST_WR: begin
          dptr  <= dptr + 1'b1;
          wleft <= wleft - 1'b1;
          state <= (wleft == 15'd1) ? ST_SNEXT : ST_RD;
        end
        ST_SNEXT: begin
          src_rd <= (src_rd + 1'b1) & smask;
          if (cur_flags[0]) state <= ST_IDLE;
          else if (total != '0) state <= ST_CLOSE;
          else begin
            in_run <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        default: begin
          dst_rd    <= (dst_rd + 1'b1) & dmask;
          in_run    <= 1'b0;
          copy_done <= 1'b1;
          state     <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/desc_copy_engine_checker.sv
`timescale 1ns/1ps
module desc_copy_engine_checker #(
  parameter int IDXW = 4
)(
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      state,
  input logic [IDXW-1:0] src_rd,
  input logic [IDXW-1:0] src_wr,
  input logic [IDXW-1:0] dst_rd,
  input logic [IDXW-1:0] dst_wr,
  input logic [IDXW-1:0] smask,
  input logic            copy_done
);
  assert_src_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd != $past(src_rd)) |-> (src_rd == (($past(src_rd) + 1'b1) & $past(smask))));

  assert_dst_moves_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_rd != $past(dst_rd)) |-> copy_done);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |=> !copy_done);

  assert_start_needs_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 3'd0 && state != 3'd0) |-> $past(src_wr != src_rd));

  assert_done_needs_posted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |-> ($past(dst_wr) != $past(dst_rd)));
endmodule

bind desc_copy_engine desc_copy_engine_checker #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .src_rd(src_rd), .src_wr(src_wr),
  .dst_rd(dst_rd), .dst_wr(dst_wr), .smask(smask), .copy_done(copy_done)
);

// File: tb/desc_copy_engine_bench.sv
`timescale 1ns/1ps
module desc_copy_engine_bench;
  localparam int AW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, mem_we = 1'b0, copy_done;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_wdata = '0, mem_rdata;
  logic [AW-1:0] mem_addr = '0;

  desc_copy_engine #(.MEM_WORDS(256), .IDXW(4)) u_desc_copy_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .copy_done(copy_done));

  always #4 clk = ~clk;

  int total = 0, bad = 0, ndone = 0;
  int sidx = 0, didx = 0, srd = 0, drd = 0;
  bit finished = 0;

  always @(posedge clk) if (rst_n && copy_done) ndone = ndone + 1;

  function automatic logic [31:0] pat(int s, int k);
    return {8'(s), 8'(k), 8'h5A, 8'(s * 3 + k)};
  endfunction
  function automatic logic [31:0] bsw(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic mem_wr(int a, logic [31:0] d);
    @(negedge clk); mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = d;
    @(negedge clk); mem_we = 1'b0;
  endtask
  task automatic mem_rd(int a, output logic [31:0] d);
    @(negedge clk); mem_addr = AW'(a); #1; d = mem_rdata;
  endtask

  function automatic int dslot(int d); return 128 + (d % 4) * 8; endfunction

  task automatic fill_src(int r, int seed);
    for (int k = 0; k < 8; k++) mem_wr(64 + r * 8 + k, pat(seed, k));
  endtask
  task automatic post_dst();
    for (int k = 0; k < 8; k++) mem_wr(dslot(didx) + k, 32'hDEAD0000 | k);
    mem_wr(32 + 2 * didx, dslot(didx) * 4);
    mem_wr(32 + 2 * didx + 1, 32'd0);
    didx = (didx + 1) % 4;
  endtask
  task automatic post_src(int r, int len, int flags);
    mem_wr(2 * sidx, (64 + r * 8) * 4);
    mem_wr(2 * sidx + 1, {16'(flags), 16'(len)});
    sidx = (sidx + 1) % 4;
  endtask
  task automatic kick();
    reg_wr(3'd5, didx);
    reg_wr(3'd4, sidx);
  endtask
  task automatic wait_done(int target);
    for (int i = 0; i < 400 && ndone < target; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask
  task automatic chk_idx(string req);
    logic [31:0] v;
    reg_rd(3'd4, v); check({req, " src read index"}, v, srd);
    reg_rd(3'd5, v); check({req, " dst read index"}, v, drd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int nd, slot, flags, nw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 copy_done at reset", copy_done, 0);
    chk_idx("R1");
    reg_rd(3'd7, v); check("R1 error flag at reset", v, 0);

    reg_wr(3'd0, 0);  reg_wr(3'd1, 4);
    reg_wr(3'd2, 32); reg_wr(3'd3, 4);
    reg_wr(3'd6, 32);

    // R3 R4 R5 R8: sweep of byte counts, metadata and swap
    for (int it = 0; it < 24; it++) begin
      int len;
      len = it + 1;
      flags = (it << 4) | ((it % 2) << 1);
      fill_src(0, it);
      slot = dslot(didx);
      post_dst();
      post_src(0, len, flags);
      nd = ndone;
      kick();
      wait_done(nd + 1);
      check("R4 one completion", ndone, nd + 1);
      srd = (srd + 1) % 4; drd = (drd + 1) % 4;
      mem_rd(32 + 2 * ((drd + 3) % 4) + 1, v);
      check("R4 dest count and flags", v, {16'(flags), 16'(len)});
      nw = (len + 3) / 4;
      for (int k = 0; k < nw; k++) begin
        mem_rd(slot + k, v);
        check((it % 2) ? "R8 swapped word" : "R3 copied word", v,
              (it % 2) ? bsw(pat(it, k)) : pat(it, k));
      end
      if (nw < 8) begin
        mem_rd(slot + nw, v); check("R3 word past end untouched", v, 32'hDEAD0000 | nw);
      end
      chk_idx("R5");
    end

    // R9: zero-length run completes nothing
    fill_src(0, 40);
    post_dst();
    post_src(0, 0, 0);
    nd = ndone;
    kick();
    repeat (60) @(negedge clk);
    srd = (srd + 1) % 4;
    check("R9 zero run no pulse", ndone, nd);
    chk_idx("R9");

    // R7: gather waits mid-run, then one completion
    fill_src(1, 50); fill_src(2, 51); fill_src(3, 52);
    slot = dslot(drd);
    post_src(1, 8, 1 | (7 << 4));
    reg_wr(3'd4, sidx);
    repeat (60) @(negedge clk);
    srd = (srd + 1) % 4;
    check("R7 no completion mid-run", ndone, nd);
    chk_idx("R7 mid-run");
    post_src(2, 8, 1);
    post_src(3, 4, 9 << 4);
    reg_wr(3'd4, sidx);
    wait_done(nd + 1);
    check("R7 single completion", ndone, nd + 1);
    srd = (srd + 2) % 4; drd = (drd + 1) % 4;
    mem_rd(32 + 2 * ((drd + 3) % 4) + 1, v);
    check("R7 gathered count", v, {16'(9 << 4), 16'd20});
    for (int k = 0; k < 5; k++) begin
      mem_rd(slot + k, v);
      check("R7 gathered word", v, pat(50 + k / 2, k % 2));
    end
    mem_rd(slot + 5, v); check("R7 past gathered end", v, 32'hDEAD0005);
    chk_idx("R7");

    // R9: oversize descriptor is skipped and flagged
    post_dst();
    slot = dslot(drd);
    post_src(0, 40, 0);
    nd = ndone;
    kick();
    repeat (60) @(negedge clk);
    srd = (srd + 1) % 4;
    check("R9 oversize no pulse", ndone, nd);
    reg_rd(3'd7, v); check("R9 error set", v, 1);
    mem_rd(32 + 2 * drd + 1, v); check("R9 dest count still zero", v, 0);
    mem_rd(slot, v); check("R9 dest data untouched", v, 32'hDEAD0000);
    chk_idx("R9 oversize");
    reg_wr(3'd7, 0);
    reg_rd(3'd7, v); check("R2 error cleared by write", v, 0);

    // R9: gather run overflow drops the overflowing descriptor
    post_src(1, 24, 1);
    post_src(2, 16, 3 << 4);
    reg_wr(3'd4, sidx);
    wait_done(nd + 1);
    check("R9 overflow run completes once", ndone, nd + 1);
    srd = (srd + 2) % 4; drd = (drd + 1) % 4;
    mem_rd(32 + 2 * ((drd + 3) % 4) + 1, v);
    check("R9 overflow run count", v, {16'(3 << 4), 16'd24});
    mem_rd(slot + 5, v); check("R9 kept word", v, pat(50, 5));
    mem_rd(slot + 6, v); check("R9 skipped data absent", v, 32'hDEAD0006);
    reg_rd(3'd7, v); check("R9 overflow error set", v, 1);
    reg_wr(3'd7, 0);
    chk_idx("R9 overflow");

    // R6: no posted destination, no start
    fill_src(0, 60);
    post_src(0, 4, 0);
    nd = ndone;
    reg_wr(3'd4, sidx);
    repeat (60) @(negedge clk);
    check("R6 no start without dest", ndone, nd);
    chk_idx("R6");
    slot = dslot(didx);
    post_dst();
    reg_wr(3'd5, didx);
    wait_done(nd + 1);
    srd = (srd + 1) % 4; drd = (drd + 1) % 4;
    check("R6 starts once dest posted", ndone, nd + 1);
    mem_rd(slot, v); check("R6 data after post", v, pat(60, 0));

    // R8: ring swap enable
    reg_wr(3'd6, 32 | (1 << 16));
    fill_src(0, 77);
    slot = dslot(didx);
    post_dst();
    post_src(0, 8, 0);
    nd = ndone;
    kick();
    wait_done(nd + 1);
    srd = (srd + 1) % 4; drd = (drd + 1) % 4;
    mem_rd(32 + 2 * ((drd + 3) % 4) + 1, v);
    check("R8 swap recorded in dest flags", v, {16'h0002, 16'd8});
    mem_rd(slot + 1, v); check("R8 ring swap word", v, bsw(pat(77, 1)));
    reg_wr(3'd6, 32);

    // R10: three pending entries, indices posted on consecutive cycles
    fill_src(1, 81); fill_src(2, 82); fill_src(3, 83);
    for (int j = 0; j < 3; j++) post_dst();
    for (int j = 0; j < 3; j++) post_src(j + 1, 4 * (j + 1), (j + 1) << 4);
    reg_wr(3'd5, didx);
    nd = ndone;
    @(negedge clk);
    for (int j = 1; j <= 3; j++) begin
      reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = (srd + j) % 4;
      @(negedge clk);
    end
    reg_we = 1'b0;
    wait_done(nd + 3);
    check("R10 three completions", ndone, nd + 3);
    for (int j = 0; j < 3; j++) begin
      mem_rd(32 + 2 * ((drd + j) % 4) + 1, v);
      check("R10 count in order", v, {16'((j + 1) << 4), 16'(4 * (j + 1))});
      mem_rd(dslot(drd + j) + j, v);
      check("R10 data in order", v, pat(81 + j, j));
    end
    srd = (srd + 3) % 4; drd = (drd + 3) % 4;
    chk_idx("R10");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule